// File: doc/BRIEF.md
# Slow-Idle Clock Enable Controller

This block puts the processor core into a waiting state on an idle command and releases it when an unmasked interrupt shows up. The idle command carries an optional divisor. Without one, the core only stops issuing instructions and every clock domain keeps running at full rate. With one, the block also thins out a set of clock-enable strobes, so that the core clock and each clock derived from it (serial clock, clock output, timer tick) run at 1/16, 1/32, 1/64 or 1/128 of the input rate. All of these domains are slowed by the same ratio and stay in step with each other.

When an unmasked interrupt is pending, the block clears its divide counter and returns every enable to full rate on the next cycle. It releases the stall and pulses a wake signal for one cycle. The core then services the interrupt and resumes at the instruction after the idle. If an unmasked interrupt is already pending when the idle command arrives, the block does not stall at all and reports the wake at once. The gating cells that consume the enables sit outside this block.

Top module: `slow_idle_ctrl`

## Requirements
- R1: After reset, `coreStall` is 0, `wakeSvc` is 0 and every bit of `clkEn` is 1.
- R2: An `idleCmd` sampled while not stalled and with `irqPending` low sets `coreStall` from the next cycle. `coreStall` stays high for as long as `irqPending` stays low, however long that is.
- R3: An idle entered with `slowReq` = 0 leaves every `clkEn` bit at 1 throughout the stall.
- R4: An idle entered with `slowReq` = 1 divides by N = 16 << `divCode` (code 0 = 16, 1 = 32, 2 = 64, 3 = 128). Counting the first stalled cycle as cycle 0, each enable strobe is high for exactly one cycle: in cycle N-1, and then every N cycles after that.
- R5: In every cycle, all `clkEn` bits carry the same value.
- R6: An `irqPending` sampled while stalled clears `coreStall` and returns every `clkEn` bit to 1 in the next cycle. In that same cycle `wakeSvc` is high, for exactly one cycle.
- R7: An `idleCmd` sampled together with `irqPending` while not stalled leaves `coreStall` at 0 and raises `wakeSvc` in the next cycle for one cycle.
- R8: An `idleCmd` that arrives while already stalled has no effect: the divisor and the strobe phase chosen at entry are kept.
- R9: `wakeSvc` is high only in the cycle that follows an exit under R6 or R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock at full rate |
| rstN | input | 1 | Asynchronous active-low reset |
| idleCmd | input | 1 | One-cycle request to enter idle |
| slowReq | input | 1 | High when the idle command carries a divisor |
| divCode | input | 2 | Divisor select: 0 = 16, 1 = 32, 2 = 64, 3 = 128 |
| irqPending | input | 1 | An unmasked interrupt is pending |
| clkEn | output | NUM_CLK | Clock-enable strobes: bit 0 core, 1 serial clock, 2 clock output, 3 timer |
| coreStall | output | 1 | Holds instruction issue while idle |
| wakeSvc | output | 1 | One-cycle pulse: service the interrupt, then continue |

## Verification
The bench builds the block with its default parameters, BASE_LOG2 = 4 and NUM_CLK = 4. These defaults make the longest divide period 128 cycles, so all four ratios, several full strobe periods of each, and the wake from a slowed state all fit in short runs. Directed cases measure the first strobe position and the strobe count for each divisor code. They also cover an idle command issued while already stalled, and an entry that finds the interrupt already pending. A long seeded random run then mixes idle commands, divisors and sparse interrupts against a cycle model.

// File: rtl/idle_pkg.sv
package idle_pkg;
  localparam int DIV_CODE_W = 2;

  typedef struct packed {
    logic load;   // capture divisor, restart counter
    logic clear;  // wake: counter back to zero
    logic count;  // advance divide counter
  } divCtl_t;
endpackage

// File: rtl/idle_div_path.sv
module idle_div_path
  import idle_pkg::*;
#(
  parameter int BASE_LOG2 = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  divCtl_t               ctl,
  input  logic [DIV_CODE_W-1:0] divCode,
  output logic                  tick
);
  localparam int MAX_LOG2 = BASE_LOG2 + (1 << DIV_CODE_W) - 1;
  localparam int CNT_W    = MAX_LOG2;

  logic [CNT_W-1:0]      cnt;
  logic [DIV_CODE_W-1:0] codeQ;
  logic [CNT_W:0]        span;
  logic [CNT_W:0]        limitFull;
  logic [CNT_W-1:0]      limit;

  always_comb begin
    span      = {{CNT_W{1'b0}}, 1'b1} << (BASE_LOG2 + int'(codeQ));
    limitFull = span - 1'b1;
    limit     = limitFull[CNT_W-1:0];
  end

  assign tick = (cnt == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      codeQ <= '0;
    end else if (ctl.load) begin
      cnt   <= '0;
      codeQ <= divCode;
    end else if (ctl.clear) begin
      cnt <= '0;
    end else if (ctl.count) begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= limit); // R4
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(codeQ)); // R8
endmodule

// File: rtl/idle_fsm.sv
module idle_fsm
  import idle_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    idleCmd,
  input  logic    slowReq,
  input  logic    irqPending,
  output divCtl_t ctl,
  output logic    slowActive,
  output logic    coreStall,
  output logic    wakeSvc
);
  logic idleQ, slowQ, wakeQ;
  logic enter, exitReq, bypass;

  assign enter   = idleCmd && !irqPending && !idleQ;
  assign bypass  = idleCmd && irqPending && !idleQ;
  assign exitReq = idleQ && irqPending;

  always_comb begin
    ctl.load  = enter;
    ctl.clear = exitReq;
    ctl.count = idleQ && slowQ && !irqPending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleQ <= 1'b0;
      slowQ <= 1'b0;
      wakeQ <= 1'b0;
    end else begin
      wakeQ <= exitReq || bypass;
      if (enter) begin
        idleQ <= 1'b1;
        slowQ <= slowReq;
      end else if (exitReq) begin
        idleQ <= 1'b0;
        slowQ <= 1'b0;
      end
    end
  end

  assign slowActive = idleQ && slowQ;
  assign coreStall  = idleQ;
  assign wakeSvc    = wakeQ;

  AST_ENTER_STALL: assert property (@(posedge clk) disable iff (!rstN)
    idleCmd && !irqPending && !coreStall |=> coreStall); // R2
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    coreStall && !irqPending |=> coreStall); // R2
  AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    coreStall && irqPending |=> !coreStall && wakeSvc); // R6
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    idleCmd && irqPending && !coreStall |=> !coreStall && wakeSvc); // R7
  AST_WAKE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    wakeSvc |=> !wakeSvc); // R9
endmodule

// File: rtl/slow_idle_ctrl.sv
module slow_idle_ctrl
  import idle_pkg::*;
#(
  parameter int BASE_LOG2 = 4,
  parameter int NUM_CLK   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  idleCmd,
  input  logic                  slowReq,
  input  logic [DIV_CODE_W-1:0] divCode,
  input  logic                  irqPending,
  output logic [NUM_CLK-1:0]    clkEn,
  output logic                  coreStall,
  output logic                  wakeSvc
);
  divCtl_t ctl;
  logic    slowActive;
  logic    tick;

  idle_fsm u_fsm (
    .clk(clk), .rstN(rstN), .idleCmd(idleCmd), .slowReq(slowReq),
    .irqPending(irqPending), .ctl(ctl), .slowActive(slowActive),
    .coreStall(coreStall), .wakeSvc(wakeSvc)
  );

  idle_div_path #(.BASE_LOG2(BASE_LOG2)) u_div (
    .clk(clk), .rstN(rstN), .ctl(ctl), .divCode(divCode), .tick(tick)
  );

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_en
    assign clkEn[g] = !slowActive || tick;
  end

  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rstN)
    !coreStall |-> &clkEn); // R6
  AST_UNIFORM: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn == '0) || (&clkEn)); // R5
endmodule

// File: tb/slow_idle_ctrl_tb.sv
module slow_idle_ctrl_tb;
  localparam int NC = 4;
  logic clk = 1'b0, rstN = 1'b0;
  logic idleCmd = 0, slowReq = 0, irqPending = 0;
  logic [1:0] divCode = 0;
  logic [NC-1:0] clkEn;
  logic coreStall, wakeSvc;
  int errors = 0, checks = 0;

  // reference model state
  logic mStall, mSlow, mWake, mImm;
  int   mCnt, mN;

  always #10 clk = ~clk;

  slow_idle_ctrl u_dut (
    .clk(clk), .rstN(rstN), .idleCmd(idleCmd), .slowReq(slowReq),
    .divCode(divCode), .irqPending(irqPending), .clkEn(clkEn),
    .coreStall(coreStall), .wakeSvc(wakeSvc)
  );

  function automatic int periodOf(input logic [1:0] c);
    return 16 << c;
  endfunction

  function automatic logic expEn();
    return !(mStall && mSlow) || (mCnt == mN - 1);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStall <= 0; mSlow <= 0; mWake <= 0; mImm <= 0; mCnt <= 0; mN <= 16;
    end else if (!mStall) begin
      mWake <= idleCmd && irqPending;
      mImm  <= idleCmd && irqPending;
      if (idleCmd && !irqPending) begin
        mStall <= 1; mSlow <= slowReq; mN <= periodOf(divCode); mCnt <= 0;
      end
    end else if (irqPending) begin
      mStall <= 0; mSlow <= 0; mWake <= 1; mImm <= 0; mCnt <= 0;
    end else begin
      mWake <= 0;
      if (mSlow) mCnt <= (mCnt == mN - 1) ? 0 : mCnt + 1;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic e;
    e = expEn();
    check(coreStall == mStall, "R2", coreStall, mStall);
    check(wakeSvc == mWake, mImm ? "R7" : "R6_R9", wakeSvc, mWake);
    check(clkEn[0] == e, (mStall && mSlow) ? "R4" : (mStall ? "R3" : "R6"), clkEn[0], e);
    check(clkEn == {NC{clkEn[0]}}, "R5", clkEn, {NC{clkEn[0]}});
  endtask

  // sample at negedge, then drive new inputs
  task automatic cyc(input logic i, input logic s, input logic [1:0] c, input logic q);
    @(negedge clk);
    compare();
    idleCmd = i; slowReq = s; divCode = c; irqPending = q;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int strobes, first;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(coreStall == 0, "R1", coreStall, 0);
    check(wakeSvc == 0, "R1", wakeSvc, 0);
    check(clkEn == '1, "R1", clkEn, 4'hF);
    rstN = 1;

    // R4: each divisor code
    for (int c = 0; c < 4; c++) begin
      int n;
      n = periodOf(2'(c));
      cyc(1, 1, 2'(c), 0);
      strobes = 0; first = -1;
      for (int i = 0; i < 2 * n; i++) begin
        cyc(0, 1, 2'(c), 0);
        if (clkEn[0]) begin strobes++; if (first < 0) first = i; end
      end
      check(first == n - 1, "R4", first, n - 1);
      check(strobes == 2, "R4", strobes, 2);
      cyc(0, 0, 0, 1);
      cyc(0, 0, 0, 0);
    end

    // R3: plain idle stays at full rate over a long wait
    cyc(1, 0, 2'd3, 0);
    for (int i = 0; i < 300; i++) cyc(0, 0, 0, 0);
    check(coreStall == 1, "R2", coreStall, 1);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);

    // R8: re-issued idle while stalled keeps divide-by-16
    cyc(1, 1, 2'd0, 0);
    cyc(0, 1, 2'd0, 0);
    cyc(1, 1, 2'd3, 0);
    strobes = 0;
    for (int i = 0; i < 64; i++) begin
      cyc(0, 1, 2'd3, 0);
      if (clkEn[0]) strobes++;
    end
    check(strobes == 4, "R8", strobes, 4);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);

    // R7: interrupt already pending at the command
    cyc(1, 1, 2'd2, 1);
    cyc(0, 0, 0, 0);
    check(coreStall == 0 && wakeSvc == 1, "R7", {coreStall, wakeSvc}, 1);
    cyc(0, 0, 0, 0);

    // random mix
    void'($urandom(32'h5eed_1d1e));
    for (int i = 0; i < 30000; i++) begin
      logic ri, rq;
      ri = ($urandom_range(0, 15) == 0);
      rq = ($urandom_range(0, 199) == 0);
      cyc(ri, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), rq);
    end
    cyc(0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule